// File: doc/BRIEF.md
# Machine-Mode External Interrupt Enable and Vector Unit

This block is the interrupt front end of a small machine-mode processor core. It samples up to 32 level-sensitive external request lines together with one software line and one timer line, each through a single register stage. It owns a per-line enable register, a one-bit vector-mode control register and the standard interrupt-enable word. From these it builds the standard pending word, decides each cycle whether an interrupt trap is requested, and computes the trap target address and the 6-bit cause code. A read-only view of the sampled external lines and a read-only view of the lowest pending-and-enabled line number are also exposed.

Software reaches the registers through a single-cycle CSR port with read, write, set and clear operations. Write data is applied at the clock edge; read data and the illegal-access flag are combinational. The core's global interrupt enable and the trap vector base are inputs, and a hold-off input lets the pipeline postpone interrupt entry without disturbing any state.

When the control bit is set, external lines bypass the standard external slot and each one gets its own vector slot above the 16 standard slots, so a handler can be entered directly per line.

Top module: `irq_vec_unit`

## Requirements
- R1: Each external line is sampled by one register stage; a read of address 0xFE8 returns the sampled lines in bits [NUM_IRQ-1:0], zero above.
- R2: The pending word at address 0x344 holds the sampled software line in bit 3, the sampled timer line in bit 7, and in bit 11 the OR over all lines of (sampled line AND its enable bit); all other bits read 0.
- R3: With hold-off low, the trap request is high exactly when the global enable input is high and at least one of these holds: bit 3 of both pending and enable words, bit 7 of both, or bit 11 of both; it follows a change of the input lines after one clock edge.
- R4: A read of address 0xFEC returns the index of the lowest-numbered line that is both sampled high and enabled, or 0 when there is none.
- R5: When bit 0 of the vector base is 0, the trap target is the base with bits [1:0] cleared and the cause is 0.
- R6: When bit 0 of the vector base is 1 and the control bit is 0, the cause is the winning standard slot (3, 7 or 11) and the target is the aligned base plus 4 times that slot (0x2C for external).
- R7: When bit 0 of the vector base is 1 and the control bit is 1, an external trap has cause (lowest line + 16) and target aligned base plus 4 times that cause.
- R8: Among standard requests the lowest bit wins (software over timer over external); with the control bit set, any enabled standard request wins over every external line.
- R9: The line-enable register at address 0xBE8 resets to ones in every implemented line and reads 0 in bits at or above NUM_IRQ, which ignore writes.
- R10: The control register at address 0xBC8 resets to 0 with only bit 0 writable; the interrupt-enable word at address 0x304 resets to 0 with only bits 3, 7 and 11 writable.
- R11: The CSR operation code is 0 for read only, 1 for write, 2 for set (OR in the data), 3 for clear (AND in the inverted data); non-writable bits keep their value under every operation.
- R12: Any operation other than read at address 0xFE8 or 0xFEC raises the illegal flag and changes no register; an access to an address not listed raises it as well; a write to the pending word is accepted, not flagged and has no effect.
- R13: While hold-off is high the trap request stays low and no register is altered; on release the request returns from the unchanged state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_ext | input | NUM_IRQ | External level-sensitive request lines |
| irq_sw | input | 1 | Software request line |
| irq_tmr | input | 1 | Timer request line |
| glob_ie | input | 1 | Global machine-mode interrupt enable from the core |
| vec_base | input | 32 | Trap vector base; bit 0 selects vectored mode |
| hold_off | input | 1 | Postpones the trap request while high |
| csr_en | input | 1 | CSR access valid this cycle |
| csr_op | input | 2 | CSR operation code (see R11) |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write/set/clear data |
| csr_rdata | output | 32 | CSR read data, zero on unknown address |
| csr_illegal | output | 1 | Access is not permitted |
| trap_req | output | 1 | Interrupt trap requested |
| trap_target | output | 32 | Trap entry address |
| trap_cause | output | 6 | Trap cause code |

## Verification
A corrupted enable bit or a wrong sampled line shows up at once on the read ports and, in the cycle after the line changes, as a trap request that is missing or spurious and a cause or target pointing at the wrong slot. A wrong control bit moves every external trap between slot 11 and slot 16 upward, so one vectored external trap exposes it, and a priority error surfaces as soon as two sources are pending together. Mask errors on the writable bits appear on the read-back of the same register one cycle after the offending write.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  localparam int XW        = 32;
  localparam int LOWEST_W  = 5;
  localparam int CAUSE_W   = 6;
  localparam int STD_SLOTS = 16;
  localparam int STD_IDX_W = $clog2(STD_SLOTS);

  // Standard bit positions inside the pending / enable words
  localparam int BIT_SW  = 3;
  localparam int BIT_TMR = 7;
  localparam int BIT_EXT = 11;

  localparam logic [XW-1:0] IE_WMASK   = 32'h0000_0888;
  localparam logic [XW-1:0] CTRL_WMASK = 32'h0000_0001;

  localparam logic [11:0] A_IE        = 12'h304;
  localparam logic [11:0] A_IP        = 12'h344;
  localparam logic [11:0] A_CTRL      = 12'hbc8;
  localparam logic [11:0] A_LINE_EN   = 12'hbe8;
  localparam logic [11:0] A_LINE_PEND = 12'hfe8;
  localparam logic [11:0] A_LOWEST    = 12'hfec;

  typedef enum logic [1:0] {
    CSR_RD  = 2'd0,
    CSR_WR  = 2'd1,
    CSR_SET = 2'd2,
    CSR_CLR = 2'd3
  } csr_op_e;

  // Apply one CSR operation, keeping non-writable bits at their old value
  function automatic logic [XW-1:0] csr_apply(csr_op_e op, logic [XW-1:0] prev,
                                              logic [XW-1:0] data, logic [XW-1:0] mask);
    logic [XW-1:0] nv;
    case (op)
      CSR_SET: nv = prev | data;
      CSR_CLR: nv = prev & ~data;
      default: nv = data;
    endcase
    return (nv & mask) | (prev & ~mask);
  endfunction

endpackage

// File: rtl/irqv_sync.sv
module irqv_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/irqv_prio.sv
// Lowest-index-wins priority encoder
module irqv_prio #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/irqv_regs.sv
module irqv_regs
  import irqv_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ok,
  input  csr_op_e            op,
  input  logic [11:0]        addr,
  input  logic [XW-1:0]      wdata,
  output logic [XW-1:0]      ie_word,
  output logic [NUM_IRQ-1:0] line_en,
  output logic               ctrl_bit
);
  localparam logic [XW-1:0] LEN_MASK = 32'hFFFF_FFFF >> (XW - NUM_IRQ);

  logic [XW-1:0]      len32;
  logic [XW-1:0]      ctrl32;
  logic [XW-1:0]      ie_nxt;
  logic [XW-1:0]      len_nxt;
  logic [XW-1:0]      ctrl_nxt;
  logic               ie_ce, len_ce, ctrl_ce;

  always_comb begin
    len32 = '0;
    len32[NUM_IRQ-1:0] = line_en;
    ctrl32 = '0;
    ctrl32[0] = ctrl_bit;
  end

  // Next-state and clock enables
  always_comb begin
    ie_ce    = wr_ok && (addr == A_IE);
    len_ce   = wr_ok && (addr == A_LINE_EN);
    ctrl_ce  = wr_ok && (addr == A_CTRL);
    ie_nxt   = csr_apply(op, ie_word, wdata, IE_WMASK);
    len_nxt  = csr_apply(op, len32,   wdata, LEN_MASK);
    ctrl_nxt = csr_apply(op, ctrl32,  wdata, CTRL_WMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_word  <= '0;
      line_en  <= '1;
      ctrl_bit <= 1'b0;
    end else begin
      if (ie_ce)   ie_word  <= ie_nxt;
      if (len_ce)  line_en  <= len_nxt[NUM_IRQ-1:0];
      if (ctrl_ce) ctrl_bit <= ctrl_nxt[0];
    end
  end
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
  import irqv_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_ext,
  input  logic               irq_sw,
  input  logic               irq_tmr,
  input  logic               glob_ie,
  input  logic [31:0]        vec_base,
  input  logic               hold_off,
  input  logic               csr_en,
  input  logic [1:0]         csr_op,
  input  logic [11:0]        csr_addr,
  input  logic [31:0]        csr_wdata,
  output logic [31:0]        csr_rdata,
  output logic               csr_illegal,
  output logic               trap_req,
  output logic [31:0]        trap_target,
  output logic [5:0]         trap_cause
);
  logic [NUM_IRQ-1:0]   line_pend;
  logic [NUM_IRQ-1:0]   line_en;
  logic [1:0]           std_q;
  logic [XW-1:0]        ie_word;
  logic                 ctrl_bit;
  logic [NUM_IRQ-1:0]   ext_hot;
  logic                 ext_pend;
  logic [LOWEST_W-1:0]  lowest;
  logic                 ext_any_unused;
  logic [XW-1:0]        pend_word;
  logic [STD_SLOTS-1:0] std_cand;
  logic [STD_IDX_W-1:0] std_idx;
  logic                 std_any;
  logic                 std_active, ext_active;
  logic [CAUSE_W-1:0]   slot;
  csr_op_e              op;
  logic                 hit, ro, wr_ok;
  logic [XW-1:0]        rd_val;

  assign op = csr_op_e'(csr_op);

  irqv_sync #(.W(NUM_IRQ)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_ext), .q(line_pend)
  );

  irqv_sync #(.W(2)) u_std_sync (
    .clk(clk), .rst_n(rst_n), .d({irq_tmr, irq_sw}), .q(std_q)
  );

  irqv_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .op(op), .addr(csr_addr),
    .wdata(csr_wdata), .ie_word(ie_word), .line_en(line_en), .ctrl_bit(ctrl_bit)
  );

  assign ext_hot  = line_pend & line_en;
  assign ext_pend = |ext_hot;

  irqv_prio #(.W(NUM_IRQ), .IW(LOWEST_W)) u_ext_prio (
    .req(ext_hot), .idx(lowest), .any(ext_any_unused)
  );

  always_comb begin
    pend_word          = '0;
    pend_word[BIT_SW]  = std_q[0];
    pend_word[BIT_TMR] = std_q[1];
    pend_word[BIT_EXT] = ext_pend;
  end

  // Standard candidates; in per-line mode the aggregate external bit leaves the set
  always_comb begin
    std_cand = pend_word[STD_SLOTS-1:0] & ie_word[STD_SLOTS-1:0];
    if (ctrl_bit) std_cand[BIT_EXT] = 1'b0;
  end

  irqv_prio #(.W(STD_SLOTS), .IW(STD_IDX_W)) u_std_prio (
    .req(std_cand), .idx(std_idx), .any(std_any)
  );

  assign std_active = glob_ie && std_any;
  assign ext_active = glob_ie && ext_pend && ie_word[BIT_EXT];

  always_comb begin
    if (!vec_base[0])    slot = '0;
    else if (std_active) slot = CAUSE_W'(std_idx);
    else                 slot = CAUSE_W'(STD_SLOTS) + CAUSE_W'(lowest);
  end

  assign trap_req    = !hold_off && (std_active || ext_active);
  assign trap_cause  = slot;
  assign trap_target = (vec_base & 32'hFFFF_FFFC) + {24'h0, slot, 2'b00};

  // CSR decode and read mux
  always_comb begin
    hit    = 1'b1;
    ro     = 1'b0;
    rd_val = '0;
    case (csr_addr)
      A_IE:      rd_val = ie_word;
      A_IP:      rd_val = pend_word;
      A_CTRL:    rd_val[0] = ctrl_bit;
      A_LINE_EN: rd_val[NUM_IRQ-1:0] = line_en;
      A_LINE_PEND: begin
        ro = 1'b1;
        rd_val[NUM_IRQ-1:0] = line_pend;
      end
      A_LOWEST: begin
        ro = 1'b1;
        rd_val[LOWEST_W-1:0] = lowest;
      end
      default: hit = 1'b0;
    endcase
  end

  assign csr_illegal = csr_en && (!hit || (ro && op != CSR_RD));
  assign wr_ok       = csr_en && (op != CSR_RD) && !csr_illegal;
  assign csr_rdata   = rd_val;

endmodule

// File: rtl/irqv_chk.sv
module irqv_chk
  import irqv_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_ext,
  input logic [NUM_IRQ-1:0] line_pend,
  input logic               glob_ie,
  input logic               hold_off,
  input logic [31:0]        vec_base,
  input logic               csr_en,
  input logic [1:0]         csr_op,
  input logic [11:0]        csr_addr,
  input logic               csr_illegal,
  input logic               trap_req,
  input logic [31:0]        trap_target,
  input logic [5:0]         trap_cause
);
  // R1: sampled lines lag the inputs by exactly one edge
  p_pend_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> line_pend == $past(irq_ext));

  // R3: no request without the global enable
  p_need_glob_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> glob_ie);

  // R5: direct mode gives cause 0 and the aligned base
  p_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !vec_base[0]) |-> (trap_cause == 6'd0 &&
      trap_target == {vec_base[31:2], 2'b00}));

  // R7: per-line slots land at base + 4*cause
  p_line_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && vec_base[0] && trap_cause >= 6'd16) |->
      trap_target == {vec_base[31:2], 2'b00} + {24'h0, trap_cause, 2'b00});

  // R12: non-read access to read-only views is flagged
  p_ro_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_op != 2'd0 && (csr_addr == A_LINE_PEND || csr_addr == A_LOWEST))
      |-> csr_illegal);

  // R13: hold-off suppresses the request
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    hold_off |-> !trap_req);
endmodule

bind irq_vec_unit irqv_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (.*);

// File: tb/sim_irq_vec_unit.sv
`timescale 1ns/100ps
module sim_irq_vec_unit;
  localparam int N = 20;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] irq_ext;
  logic         irq_sw, irq_tmr, glob_ie, hold_off;
  logic [31:0]  vec_base;
  logic         csr_en;
  logic [1:0]   csr_op;
  logic [11:0]  csr_addr;
  logic [31:0]  csr_wdata;
  logic [31:0]  csr_rdata;
  logic         csr_illegal;
  logic         trap_req;
  logic [31:0]  trap_target;
  logic [5:0]   trap_cause;

  int nvec = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  irq_vec_unit #(.NUM_IRQ(N)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_ext(irq_ext), .irq_sw(irq_sw), .irq_tmr(irq_tmr),
    .glob_ie(glob_ie), .vec_base(vec_base), .hold_off(hold_off), .csr_en(csr_en),
    .csr_op(csr_op), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_illegal(csr_illegal), .trap_req(trap_req), .trap_target(trap_target),
    .trap_cause(trap_cause)
  );

  localparam logic [11:0] IE = 12'h304, IP = 12'h344, CTRL = 12'hbc8,
                          LEN = 12'hbe8, LPEND = 12'hfe8, LOW = 12'hfec;
  // R11: op codes
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, ST = 2'd2, CL = 2'd3;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, output logic ill);
    csr_en = 1'b1; csr_op = RD; csr_addr = a; csr_wdata = '0;
    #1;
    d = csr_rdata; ill = csr_illegal;
    tick();
    csr_en = 1'b0;
  endtask

  task automatic wr(logic [1:0] op, logic [11:0] a, logic [31:0] v, output logic ill);
    csr_en = 1'b1; csr_op = op; csr_addr = a; csr_wdata = v;
    #1;
    ill = csr_illegal;
    tick();
    csr_en = 1'b0;
  endtask

  task automatic expect_rd(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d; logic ill;
    rd(a, d, ill);
    check(req, d, exp);
  endtask

  task automatic w(logic [1:0] op, logic [11:0] a, logic [31:0] v);
    logic ill;
    wr(op, a, v, ill);
  endtask

  task automatic expect_trap(string req, logic r, logic [5:0] c, logic [31:0] t);
    check(req, {31'h0, trap_req}, {31'h0, r});
    if (r) begin
      check(req, {26'h0, trap_cause}, {26'h0, c});
      check(req, trap_target, t);
    end
  endtask

  task automatic t_reset();
    check("R3 reset", {31'h0, trap_req}, 32'h0);
    expect_rd("R9 reset enables", LEN, 32'h000F_FFFF);
    expect_rd("R10 reset ctrl", CTRL, 32'h0);
    expect_rd("R10 reset ie", IE, 32'h0);
    expect_rd("R2 reset pend word", IP, 32'h0);
  endtask

  task automatic t_masks();
    w(WR, IE, 32'hFFFF_FFFF);  expect_rd("R10 ie mask", IE, 32'h888);
    w(CL, IE, 32'h8);          expect_rd("R11 clear", IE, 32'h880);
    w(ST, IE, 32'h8);          expect_rd("R11 set", IE, 32'h888);
    w(WR, CTRL, 32'hFFFF_FFFF); expect_rd("R10 ctrl mask", CTRL, 32'h1);
    w(WR, CTRL, 32'h0);        expect_rd("R10 ctrl clear", CTRL, 32'h0);
    w(WR, LEN, 32'hFFFF_FFFF); expect_rd("R9 upper bits", LEN, 32'h000F_FFFF);
    w(CL, LEN, 32'h3);         expect_rd("R11 clear enables", LEN, 32'h000F_FFFC);
    w(ST, LEN, 32'hFFF0_0003); expect_rd("R9 set upper ignored", LEN, 32'h000F_FFFF);
  endtask

  task automatic t_lines();
    w(WR, IE, 32'h800);
    glob_ie = 1'b1; vec_base = 32'h8000_0002;
    irq_ext = 20'h00410;
    #1;
    check("R3 not before edge", {31'h0, trap_req}, 32'h0);
    tick();
    expect_trap("R3 R5 direct", 1'b1, 6'd0, 32'h8000_0000);
    expect_rd("R1 line view", LPEND, 32'h0000_0410);
    expect_rd("R4 lowest", LOW, 32'd4);
    expect_rd("R2 ext bit", IP, 32'h800);
    w(CL, LEN, 32'h10);
    expect_rd("R4 lowest after mask", LOW, 32'd10);
    w(CL, LEN, 32'h400);
    expect_rd("R2 all masked", IP, 32'h0);
    check("R2 no request when masked", {31'h0, trap_req}, 32'h0);
    expect_rd("R4 none", LOW, 32'd0);
    w(ST, LEN, 32'h410);
    irq_ext = '0;
    tick();
    check("R3 drop after lines fall", {31'h0, trap_req}, 32'h0);
  endtask

  task automatic t_vectors();
    vec_base = 32'h8000_0103;
    irq_ext = 20'h00410;
    tick();
    expect_trap("R6 ext slot 11", 1'b1, 6'd11, 32'h8000_012C);
    w(WR, CTRL, 32'h1);
    expect_trap("R7 line 4", 1'b1, 6'd20, 32'h8000_0150);
    irq_ext = 20'h80000;
    tick();
    expect_trap("R7 line 19", 1'b1, 6'd35, 32'h8000_018C);
  endtask

  task automatic t_priority();
    w(WR, IE, 32'h888);
    irq_ext = 20'h00410; irq_sw = 1'b1; irq_tmr = 1'b1;
    tick();
    expect_trap("R8 sw first", 1'b1, 6'd3, 32'h8000_010C);
    irq_sw = 1'b0; tick();
    expect_trap("R8 timer over lines", 1'b1, 6'd7, 32'h8000_011C);
    irq_tmr = 1'b0; tick();
    expect_trap("R7 line after std gone", 1'b1, 6'd20, 32'h8000_0150);
    w(WR, CTRL, 32'h0);
    irq_tmr = 1'b1; tick();
    expect_trap("R8 timer over slot 11", 1'b1, 6'd7, 32'h8000_011C);
    irq_tmr = 1'b0; tick();
    expect_trap("R6 slot 11", 1'b1, 6'd11, 32'h8000_012C);
    w(CL, IE, 32'h800);
    check("R3 ext enable off", {31'h0, trap_req}, 32'h0);
    expect_rd("R2 pend kept", IP, 32'h800);
    irq_sw = 1'b1; glob_ie = 1'b0; tick();
    check("R3 global off", {31'h0, trap_req}, 32'h0);
    glob_ie = 1'b1; irq_sw = 1'b0; irq_ext = '0; tick();
  endtask

  task automatic t_illegal();
    logic ill; logic [31:0] d;
    wr(WR, LPEND, 32'hFFFF_FFFF, ill); check("R12 write line view", {31'h0, ill}, 32'h1);
    wr(ST, LOW, 32'h1F, ill);          check("R12 set lowest", {31'h0, ill}, 32'h1);
    rd(LPEND, d, ill);                 check("R12 read line view ok", {31'h0, ill}, 32'h0);
    check("R12 line view unchanged", d, 32'h0);
    wr(WR, IP, 32'hFFFF_FFFF, ill);    check("R12 pend word write ok", {31'h0, ill}, 32'h0);
    expect_rd("R12 pend word no effect", IP, 32'h0);
    rd(12'h123, d, ill);               check("R12 unknown address", {31'h0, ill}, 32'h1);
    check("R12 unknown reads zero", d, 32'h0);
    expect_rd("R12 ie untouched", IE, 32'h088);
  endtask

  task automatic t_hold();
    vec_base = 32'h8000_0101;
    irq_sw = 1'b1; hold_off = 1'b1;
    tick();
    check("R13 held", {31'h0, trap_req}, 32'h0);
    expect_rd("R13 ie unchanged", IE, 32'h088);
    hold_off = 1'b0; #1;
    expect_trap("R13 release", 1'b1, 6'd3, 32'h8000_010C);
    irq_sw = 1'b0;
    tick();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("watchdog expired");
    nfail++;
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_ext = '0; irq_sw = 1'b0; irq_tmr = 1'b0; glob_ie = 1'b0;
    hold_off = 1'b0; vec_base = '0; csr_en = 1'b0; csr_op = RD; csr_addr = '0;
    csr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_lines();
    t_vectors();
    t_priority();
    t_illegal();
    t_hold();
    summary();
    $finish;
  end
endmodule